// File: doc/BRIEF.md
# Dual-Source Power Path Selector Controller

This block is the digital decision core behind two bidirectional power switches that join two external supply ports to one shared output rail. It takes digitized comparator flags for each port (rise past the detect threshold, fall below the release threshold, over-voltage, reverse polarity), a collapsed-rail flag, a die over-temperature flag, a preference pin and two reverse-mode enable pins. From these it decides which switch is closed and drives two switch-enable outputs and two active-low status outputs.

In forward mode it picks an available source on its own, using the preference pin only when both ports carry power. In reverse mode an enable pin forces its switch closed so the shared rail can feed a device on that port. Once closed this way, the switch stays closed until the rail collapses. Faults open switches at once. Any closing of a switch waits until all switches have been open for a break-before-make gap, and reverse-mode closures also wait a turn-on delay. Both intervals are clock-count parameters. Every asynchronous input passes through a two-flop synchronizer. In that synchronizer the preference input resets high and the enables reset low, as a pull-up and pull-downs would.

Top module: `dual_source_selector`

## Requirements
- R1: In forward mode with both ports present, preferPortTwo low closes switch 1 (bit 0) only, and preferPortTwo high closes switch 2 (bit 1) only.
- R2: In forward mode with exactly one port present, only that port's switch closes, whatever preferPortTwo is. With no port present, both switches are open.
- R3: While rstN is low, both switches are open and both status outputs are high.
- R4: A port becomes present when its aboveDetect flag is high and stops being present only when its belowRelease flag is high. With both flags low, presence keeps its last value.
- R5: A high reverseEnable[x] closes switch x whatever the presence flags and preferPortTwo say. The two enables act independently, so both switches may be closed together.
- R6: A switch closed by its reverse enable stays closed after the enable falls, and opens once railCollapsed is high.
- R7: A high overVolt[x] opens switch x within 4 cycles, overriding preference and both enables. The switch closes again once the flag clears.
- R8: A high revPolarity on either port opens both switches within 4 cycles.
- R9: A switch closes only after all switches have been open for at least GAP_CYCLES consecutive cycles. This also holds when the new state has both switches closed.
- R10: After reverseEnable[x] rises, switch x stays open for at least ON_DELAY_CYCLES cycles.
- R11: A high thermalTrip opens both switches within 4 cycles. When it clears, the switches return to the state they held before, including a latched reverse connection.
- R12: statusN[x] is low exactly when switchOn[x] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aboveDetect | input | 2 | Per-port flag: voltage above the detect threshold |
| belowRelease | input | 2 | Per-port flag: voltage below the release threshold |
| overVolt | input | 2 | Per-port over-voltage flag |
| revPolarity | input | 2 | Per-port negative-voltage flag |
| railCollapsed | input | 1 | Shared output rail near 0 V |
| thermalTrip | input | 1 | Die over-temperature flag (hysteresis applied upstream) |
| preferPortTwo | input | 1 | Preference pin: high prefers port 2 when both are present |
| reverseEnable | input | 2 | Per-port reverse-mode enable |
| switchOn | output | 2 | Switch close enables, bit 0 is switch 1 |
| statusN | output | 2 | Active-low switch status |

## Verification
The hardest states to reach from the ports are a latched reverse connection whose enable has already fallen while a thermal or polarity fault arrives and clears, and the move from one closed switch to both closed, which must still open everything for the full gap. Directed sequences build these states step by step. They raise an enable, let the switch latch, drop the enable, then pulse each fault, and they sample inside the gap window and after it. A seeded random phase moves each port between high, middle and low voltage bands, toggles the preference pin and sprinkles faults, to cover the forward selection and the hysteresis.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int NUM_PORTS = 2;

  // Raw and synchronized view of every asynchronous input
  typedef struct packed {
    logic [NUM_PORTS-1:0] riseSeen;
    logic [NUM_PORTS-1:0] releaseSeen;
    logic [NUM_PORTS-1:0] overVolt;
    logic [NUM_PORTS-1:0] revPolarity;
    logic                 railLow;
    logic                 hotDie;
    logic                 preferTwo;
    logic [NUM_PORTS-1:0] revRequest;
  } senseVec_t;

  // Preference pulled high, everything else low while undriven
  localparam senseVec_t SENSE_RESET = '{preferTwo: 1'b1, default: '0};

  // Inputs the control uses directly
  typedef struct packed {
    logic [NUM_PORTS-1:0] overVolt;
    logic [NUM_PORTS-1:0] revPolarity;
    logic                 hotDie;
    logic                 preferTwo;
  } guardVec_t;

  // State the datapath reports to the control
  typedef struct packed {
    logic [NUM_PORTS-1:0] present;
    logic [NUM_PORTS-1:0] revArmed;
    logic [NUM_PORTS-1:0] revLatched;
    logic                 gapDone;
    logic [NUM_PORTS-1:0] closed;
  } pathState_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,  // keep switches as they are
    ACT_TRIM  = 2'd1,  // open some switches, close none
    ACT_BREAK = 2'd2,  // open all switches to start the gap
    ACT_MAKE  = 2'd3   // gap served: load the new connection
  } seqAct_e;

  typedef struct packed {
    seqAct_e              act;
    logic [NUM_PORTS-1:0] value;
  } seqStrobe_t;

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int               WIDTH     = 1,
  parameter int               STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int GAP_CYCLES      = 50000,
  parameter int ON_DELAY_CYCLES = 12500
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] riseSeen,
  input  logic [NUM_PORTS-1:0] releaseSeen,
  input  logic [NUM_PORTS-1:0] revRequest,
  input  logic                 railLow,
  input  seqStrobe_t           strobe,
  output pathState_t           state
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int ON_W  = $clog2(ON_DELAY_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES);
  localparam logic [ON_W-1:0]  ON_LAST  = ON_W'(ON_DELAY_CYCLES);

  logic [NUM_PORTS-1:0] present;
  logic [NUM_PORTS-1:0] armed;
  logic [NUM_PORTS-1:0] latched;
  logic [NUM_PORTS-1:0] closed;
  logic [GAP_W-1:0]     offCount;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic            presentQ;
    logic            latchQ;
    logic [ON_W-1:0] enCount;

    // Hysteresis: set above the detect level, clear below the release level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               presentQ <= 1'b0;
      else if (riseSeen[p])    presentQ <= 1'b1;
      else if (releaseSeen[p]) presentQ <= 1'b0;
    end

    // Turn-on delay counter for the reverse enable
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                enCount <= '0;
      else if (!revRequest[p])  enCount <= '0;
      else if (enCount != ON_LAST) enCount <= enCount + 1'b1;
    end

    // Reverse connection latch, released by a collapsed rail
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       latchQ <= 1'b0;
      else if (railLow)                latchQ <= 1'b0;
      else if (closed[p] && armed[p])  latchQ <= 1'b1;
    end

    assign present[p] = presentQ;
    assign latched[p] = latchQ;
    assign armed[p]   = revRequest[p] && (enCount == ON_LAST);
  end

  // Applied switch state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      closed <= '0;
    end else begin
      case (strobe.act)
        ACT_TRIM, ACT_MAKE: closed <= strobe.value;
        ACT_BREAK:          closed <= '0;
        default:            closed <= closed;
      endcase
    end
  end

  // Consecutive all-open cycles, saturating at the gap length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  offCount <= '0;
    else if (closed != '0)      offCount <= '0;
    else if (offCount != GAP_LAST) offCount <= offCount + 1'b1;
  end

  assign state = '{present:    present,
                   revArmed:   armed,
                   revLatched: latched,
                   gapDone:    (offCount == GAP_LAST),
                   closed:     closed};

endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
(
  input  guardVec_t  guard,
  input  pathState_t state,
  output seqStrobe_t strobe
);

  logic [NUM_PORTS-1:0] revWant;
  logic [NUM_PORTS-1:0] fwdWant;
  logic [NUM_PORTS-1:0] want;
  logic [NUM_PORTS-1:0] adds;

  // Target connection
  always_comb begin
    revWant = state.revArmed | state.revLatched;
    unique case (state.present)
      2'b01:   fwdWant = 2'b01;
      2'b10:   fwdWant = 2'b10;
      2'b11:   fwdWant = guard.preferTwo ? 2'b10 : 2'b01;
      default: fwdWant = 2'b00;
    endcase
    want = (revWant != '0) ? revWant : fwdWant;
    want = want & ~guard.overVolt;
    if ((guard.revPolarity != '0) || guard.hotDie) want = '0;
  end

  // Sequencing: openings at once, closings only after a served gap
  always_comb begin
    adds   = want & ~state.closed;
    strobe = '{act: ACT_HOLD, value: want};
    if (want == state.closed)       strobe.act = ACT_HOLD;
    else if (adds == '0)            strobe.act = ACT_TRIM;
    else if (state.closed != '0)    strobe.act = ACT_BREAK;
    else if (state.gapDone)         strobe.act = ACT_MAKE;
    else                            strobe.act = ACT_HOLD;
  end

endmodule

// File: rtl/dual_source_selector.sv
module dual_source_selector
  import pps_pkg::*;
#(
  parameter int GAP_CYCLES      = 50000,
  parameter int ON_DELAY_CYCLES = 12500,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] aboveDetect,
  input  logic [1:0] belowRelease,
  input  logic [1:0] overVolt,
  input  logic [1:0] revPolarity,
  input  logic       railCollapsed,
  input  logic       thermalTrip,
  input  logic       preferPortTwo,
  input  logic [1:0] reverseEnable,
  output logic [1:0] switchOn,
  output logic [1:0] statusN
);

  senseVec_t  senseRaw;
  senseVec_t  senseSync;
  guardVec_t  guard;
  pathState_t state;
  seqStrobe_t strobe;

  logic [1:0] syncOv;
  logic [1:0] syncPol;
  logic       syncHot;

  assign senseRaw = '{riseSeen:    aboveDetect,
                      releaseSeen: belowRelease,
                      overVolt:    overVolt,
                      revPolarity: revPolarity,
                      railLow:     railCollapsed,
                      hotDie:      thermalTrip,
                      preferTwo:   preferPortTwo,
                      revRequest:  reverseEnable};

  pps_sync #(
    .WIDTH    ($bits(senseVec_t)),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(SENSE_RESET)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(senseRaw),
    .syncOut(senseSync)
  );

  assign guard = '{overVolt:    senseSync.overVolt,
                   revPolarity: senseSync.revPolarity,
                   hotDie:      senseSync.hotDie,
                   preferTwo:   senseSync.preferTwo};

  assign syncOv  = senseSync.overVolt;
  assign syncPol = senseSync.revPolarity;
  assign syncHot = senseSync.hotDie;

  pps_datapath #(
    .GAP_CYCLES     (GAP_CYCLES),
    .ON_DELAY_CYCLES(ON_DELAY_CYCLES)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .riseSeen   (senseSync.riseSeen),
    .releaseSeen(senseSync.releaseSeen),
    .revRequest (senseSync.revRequest),
    .railLow    (senseSync.railLow),
    .strobe     (strobe),
    .state      (state)
  );

  pps_ctrl u_ctrl (
    .guard (guard),
    .state (state),
    .strobe(strobe)
  );

  assign switchOn = state.closed;
  assign statusN  = ~state.closed;

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int GAP_CYCLES = 50000
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] switchOn,
  input logic [1:0] ovSync,
  input logic [1:0] polSync,
  input logic       hotSync
);

  localparam int RUN_W = $clog2(GAP_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(GAP_CYCLES);

  logic [1:0]       prevSw;
  logic [RUN_W-1:0] offRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSw <= 2'b00;
      offRun <= '0;
    end else begin
      prevSw <= switchOn;
      if (switchOn != 2'b00)   offRun <= '0;
      else if (offRun != RUN_TOP) offRun <= offRun + 1'b1;
    end
  end

  // R9: any closing is preceded by a full all-open gap
  assert_gap_before_close_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((switchOn & ~prevSw) != 2'b00) |-> ((prevSw == 2'b00) && (offRun == RUN_TOP)))
    else $error("gap rule broken");

  // R7: an over-voltage port is open one cycle after its synchronized flag
  assert_ov_opens_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ovSync != 2'b00) |=> ((switchOn & $past(ovSync)) == 2'b00))
    else $error("over-voltage port still closed");

  // R8: a polarity fault opens everything
  assert_pol_opens_R8: assert property (@(posedge clk) disable iff (!rstN)
    (polSync != 2'b00) |=> (switchOn == 2'b00))
    else $error("polarity fault left a switch closed");

  // R11: a thermal fault opens everything
  assert_hot_opens_R11: assert property (@(posedge clk) disable iff (!rstN)
    hotSync |=> (switchOn == 2'b00))
    else $error("thermal fault left a switch closed");

endmodule

bind dual_source_selector dss_checker #(.GAP_CYCLES(GAP_CYCLES)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .switchOn(switchOn),
  .ovSync  (syncOv),
  .polSync (syncPol),
  .hotSync (syncHot)
);

// File: tb/dual_source_selector_test.sv
module dual_source_selector_test;

  localparam int GAP = 20;
  localparam int OND = 8;
  localparam int SETTLE = GAP + OND + 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] aboveDetect = 2'b00;
  logic [1:0] belowRelease = 2'b11;
  logic [1:0] overVolt = 2'b00;
  logic [1:0] revPolarity = 2'b00;
  logic       railCollapsed = 1'b0;
  logic       thermalTrip = 1'b0;
  logic       preferPortTwo = 1'b1;
  logic [1:0] reverseEnable = 2'b00;
  logic [1:0] switchOn;
  logic [1:0] statusN;

  int checks = 0;
  int errors = 0;
  logic [1:0] presModel = 2'b00;

  always #4 clk = ~clk;

  dual_source_selector #(.GAP_CYCLES(GAP), .ON_DELAY_CYCLES(OND)) uut (
    .clk(clk), .rstN(rstN), .aboveDetect(aboveDetect), .belowRelease(belowRelease),
    .overVolt(overVolt), .revPolarity(revPolarity), .railCollapsed(railCollapsed),
    .thermalTrip(thermalTrip), .preferPortTwo(preferPortTwo),
    .reverseEnable(reverseEnable), .switchOn(switchOn), .statusN(statusN));

  // Gap monitor for R9
  logic [1:0] prevSample = 2'b00;
  int zeroRun = 0;
  int gapViolations = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevSample = 2'b00;
      zeroRun = 0;
    end else begin
      if ((switchOn & ~prevSample) != 2'b00)
        if (prevSample != 2'b00 || zeroRun < GAP) gapViolations++;
      zeroRun = (switchOn == 2'b00) ? zeroRun + 1 : 0;
      prevSample = switchOn;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOut(input string tag, input logic [1:0] expSw);
    checks++;
    if (switchOn !== expSw) begin
      errors++;
      $display("FAIL %s switchOn actual=%b expected=%b", tag, switchOn, expSw);
    end
    checks++;
    if (statusN !== ~expSw) begin
      errors++;
      $display("FAIL R12 (%s) statusN actual=%b expected=%b", tag, statusN, ~expSw);
    end
  endtask

  // level: 0 below release, 1 between thresholds, 2 above detect
  task automatic setLevel(input int p, input int level);
    aboveDetect[p]  = (level == 2);
    belowRelease[p] = (level == 0);
    if (level == 2) presModel[p] = 1'b1;
    else if (level == 0) presModel[p] = 1'b0;
  endtask

  function automatic logic [1:0] expectFwd(input logic [1:0] pres, input logic pref,
                                           input logic [1:0] ov, input logic [1:0] pol,
                                           input logic hot);
    logic [1:0] w;
    case (pres)
      2'b01:   w = 2'b01;
      2'b10:   w = 2'b10;
      2'b11:   w = pref ? 2'b10 : 2'b01;
      default: w = 2'b00;
    endcase
    w = w & ~ov;
    if (pol != 2'b00 || hot) w = 2'b00;
    return w;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'h5EED_0042);

    waitCycles(3);
    checkOut("R3 reset", 2'b00);
    rstN = 1'b1;
    waitCycles(SETTLE);
    checkOut("R2 none present", 2'b00);

    // R1
    setLevel(0, 2); setLevel(1, 2); preferPortTwo = 1'b0;
    waitCycles(SETTLE);
    checkOut("R1 prefer low", 2'b01);
    preferPortTwo = 1'b1;
    waitCycles(6);
    checkOut("R9 gap during swap", 2'b00);
    waitCycles(SETTLE);
    checkOut("R1 prefer high", 2'b10);

    // R2
    setLevel(1, 0);
    waitCycles(SETTLE);
    checkOut("R2 port1 only", 2'b01);
    setLevel(0, 0); setLevel(1, 2); preferPortTwo = 1'b0;
    waitCycles(SETTLE);
    checkOut("R2 port2 only", 2'b10);

    // R4 hysteresis
    setLevel(1, 1);
    waitCycles(SETTLE);
    checkOut("R4 mid band keeps present", 2'b10);
    setLevel(1, 0);
    waitCycles(SETTLE);
    checkOut("R4 release drops", 2'b00);
    setLevel(1, 1);
    waitCycles(SETTLE);
    checkOut("R4 mid band keeps absent", 2'b00);

    // Random forward phase
    for (int it = 0; it < 60; it++) begin
      string tag;
      logic [1:0] expv;
      setLevel(0, $urandom_range(0, 2));
      setLevel(1, $urandom_range(0, 2));
      preferPortTwo = $urandom_range(0, 1);
      overVolt[0] = ($urandom_range(0, 5) == 0);
      overVolt[1] = ($urandom_range(0, 5) == 0);
      revPolarity = ($urandom_range(0, 9) == 0) ? 2'b10 : 2'b00;
      thermalTrip = ($urandom_range(0, 9) == 0);
      waitCycles(SETTLE);
      expv = expectFwd(presModel, preferPortTwo, overVolt, revPolarity, thermalTrip);
      if (revPolarity != 2'b00) tag = "R8 random";
      else if (thermalTrip) tag = "R11 random";
      else if (overVolt != 2'b00) tag = "R7 random";
      else if (presModel == 2'b11) tag = "R1 random";
      else tag = "R2 random";
      checkOut(tag, expv);
    end
    overVolt = 2'b00; revPolarity = 2'b00; thermalTrip = 1'b0;

    // Reverse mode: R10, R5
    setLevel(0, 0); setLevel(1, 0); preferPortTwo = 1'b0;
    waitCycles(SETTLE);
    checkOut("R2 cleared", 2'b00);
    reverseEnable[0] = 1'b1;
    waitCycles(OND);
    checkOut("R10 still open in delay", 2'b00);
    waitCycles(SETTLE);
    checkOut("R5 enable overrides absence", 2'b01);
    setLevel(1, 2); preferPortTwo = 1'b1;
    waitCycles(SETTLE);
    checkOut("R5 overrides preference", 2'b01);
    reverseEnable[1] = 1'b1;
    waitCycles(OND + 4);
    checkOut("R9 gap before both on", 2'b00);
    waitCycles(SETTLE);
    checkOut("R5 both closed", 2'b11);

    // R6 latch until collapse
    setLevel(1, 0);
    reverseEnable = 2'b00;
    waitCycles(SETTLE);
    checkOut("R6 latched after enable drop", 2'b11);
    railCollapsed = 1'b1;
    waitCycles(5);
    checkOut("R6 collapse opens", 2'b00);
    railCollapsed = 1'b0;
    waitCycles(SETTLE);
    checkOut("R6 stays open after rail back", 2'b00);

    // R7 in reverse mode
    reverseEnable[0] = 1'b1;
    waitCycles(SETTLE);
    checkOut("R5 port1 reverse", 2'b01);
    overVolt[0] = 1'b1;
    waitCycles(4);
    checkOut("R7 overrides enable", 2'b00);
    overVolt[0] = 1'b0;
    waitCycles(SETTLE);
    checkOut("R7 recloses after clear", 2'b01);

    // R11 restore of a latched connection, R8
    reverseEnable[0] = 1'b0;
    waitCycles(SETTLE);
    checkOut("R6 latched port1", 2'b01);
    thermalTrip = 1'b1;
    waitCycles(4);
    checkOut("R11 thermal opens", 2'b00);
    thermalTrip = 1'b0;
    waitCycles(SETTLE);
    checkOut("R11 restored", 2'b01);
    revPolarity[1] = 1'b1;
    waitCycles(4);
    checkOut("R8 polarity opens", 2'b00);
    revPolarity[1] = 1'b0;
    waitCycles(SETTLE);
    checkOut("R8 restored after clear", 2'b01);
    railCollapsed = 1'b1;
    waitCycles(5);
    checkOut("R6 final collapse", 2'b00);

    checks++;
    if (gapViolations != 0) begin
      errors++;
      $display("FAIL R9 gap violations actual=%0d expected=0", gapViolations);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule